// File: doc/BRIEF.md
# Min-Sum Variable Node Update Unit

This block performs the variable-side half of one iteration of a min-sum LDPC decoder, for a single variable node joined to `WC` check nodes. Each call, it takes the channel estimate for the bit and one incoming message from every attached check node, all in sign-magnitude form. It returns one fresh message toward every check node and the posterior estimate of the bit.

All inputs are first turned into two's complement and summed in an accumulator wide enough that it can never overflow. That sum is the posterior, and it leaves the block unclamped. Each outgoing message is the sum with the contribution from its own destination taken back out. The result is clamped to the message width and put back into sign-magnitude form. The posterior's sign gives the hard decision; a zero or positive posterior means the bit is a 0.

One set of inputs is accepted per cycle when `in_valid` is high. The results appear one clock later together with `out_valid`. A surrounding scheduler supplies messages from memory and consumes the results.

Top module: `vnu_core`

## Requirements
- R1: One cycle after `in_valid`, `post_o` read as a `SUM_W`-bit two's complement number equals the channel value plus the sum of all `WC` incoming messages. Here `SUM_W` = `MSG_W` + ceil(log2(`WC`+1)), so that sum never wraps.
- R2: One cycle after `in_valid`, outgoing slot i equals the saturated value of (channel value + sum of all incoming messages except slot i).
- R3: A sum above +(2^(`MSG_W`-1)-1) is output as sign 0 with all magnitude bits set. A sum below -(2^(`MSG_W`-1)-1) is output as sign 1 with all magnitude bits set.
- R4: Every message is sign-magnitude, with bit `MSG_W`-1 as the sign (1 = negative) and the lower bits as the magnitude. Message slot i occupies bits [i*`MSG_W` +: `MSG_W`] of the flat buses. An input with zero magnitude and sign 1 counts as zero. An output never carries sign 1 with zero magnitude.
- R5: When all incoming messages are zero, every outgoing message equals the channel value, and the posterior equals the channel value as well.
- R6: `out_valid` is `in_valid` delayed by exactly one clock.
- R7: While `in_valid` is low, `v2c_o` and `post_o` keep their previous values.
- R8: While `rst` is high, at the next edge `out_valid`, `v2c_o` and `post_o` are all cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input set is presented this cycle |
| lambda_i | input | MSG_W | Channel value, sign-magnitude |
| c2v_i | input | WC*MSG_W | Incoming check messages, sign-magnitude, slot i at [i*MSG_W +: MSG_W] |
| out_valid | output | 1 | Results below are from the previous accepted input |
| v2c_o | output | WC*MSG_W | Outgoing messages, saturated, sign-magnitude |
| post_o | output | SUM_W | Posterior sum, two's complement |

## Verification
Two functions can act in the same cycle: the removal of a slot's own contribution, and the clamp that follows it. When the total is far out of range, some slots stay saturated after their own message is removed, while a slot holding a large message falls back into range. The stimulus table contains such a mix. Examples are a total of 16 where one slot yields 10 and the rest clamp to 15, and both all-positive and all-negative full-scale inputs. Every slot is compared against a per-slot expectation that the bench computes from signed integers. Negative-zero inputs are placed beside ordinary values, so that both the conversion and the zero-sign rule are judged on the same output word.

// File: rtl/vnu_pkg.sv
package vnu_pkg;

    localparam int VNU_MSG_W = 5;
    localparam int VNU_WC    = 6;

    // Outcome of clamping a wide sum into a message word
    typedef enum logic [1:0] {
        CLAMP_NONE = 2'd0,
        CLAMP_POS  = 2'd1,
        CLAMP_NEG  = 2'd2
    } clamp_e;

    // Accumulator width: large enough for WC+1 full-scale terms
    function automatic int vnu_sum_w(input int msg_w, input int wc);
        return msg_w + $clog2(wc + 1);
    endfunction

    // Largest magnitude a sign-magnitude word of width w can carry
    function automatic int vnu_max_mag(input int w);
        return (1 << (w - 1)) - 1;
    endfunction

endpackage

// File: rtl/vnu_sm2tc.sv
module vnu_sm2tc #(
    parameter int IN_W  = 5,
    parameter int OUT_W = 8
) (
    input  logic [IN_W-1:0]  sm_i,
    output logic [OUT_W-1:0] tc_o
);
    logic [OUT_W-1:0] mag_ext;

    assign mag_ext = {{(OUT_W - IN_W + 1){1'b0}}, sm_i[IN_W-2:0]};
    // Negating a zero magnitude yields zero, so a negative zero collapses
    assign tc_o    = sm_i[IN_W-1] ? (~mag_ext + 1'b1) : mag_ext;

endmodule

// File: rtl/vnu_accum.sv
module vnu_accum #(
    parameter int W = 8,
    parameter int N = 7
) (
    input  logic [N-1:0][W-1:0] term_i,
    output logic [W-1:0]        sum_o
);
    always_comb begin
        sum_o = '0;
        for (int k = 0; k < N; k++) begin
            sum_o = sum_o + term_i[k];
        end
    end

endmodule

// File: rtl/vnu_sat_tc2sm.sv
module vnu_sat_tc2sm
    import vnu_pkg::*;
#(
    parameter int IN_W  = 8,
    parameter int OUT_W = 5
) (
    input  logic [IN_W-1:0]  tc_i,
    output logic [OUT_W-1:0] sm_o
);
    localparam int                    MAX_MAG = vnu_max_mag(OUT_W);
    localparam logic signed [IN_W-1:0] LIM_P  = IN_W'(MAX_MAG);
    localparam logic signed [IN_W-1:0] LIM_N  = -LIM_P;

    clamp_e          kind;
    logic            neg;
    logic [IN_W-1:0] absv;
    logic            unused_hi;

    always_comb begin
        if ($signed(tc_i) > LIM_P)      kind = CLAMP_POS;
        else if ($signed(tc_i) < LIM_N) kind = CLAMP_NEG;
        else                            kind = CLAMP_NONE;
    end

    assign neg       = tc_i[IN_W-1];
    assign absv      = neg ? (~tc_i + 1'b1) : tc_i;
    assign unused_hi = ^absv[IN_W-1:OUT_W-1];

    always_comb begin
        unique case (kind)
            CLAMP_POS: sm_o = {1'b0, {(OUT_W-1){1'b1}}};
            CLAMP_NEG: sm_o = {1'b1, {(OUT_W-1){1'b1}}};
            default:   sm_o = {neg, absv[OUT_W-2:0]};
        endcase
    end

endmodule

// File: rtl/vnu_core.sv
module vnu_core
    import vnu_pkg::*;
#(
    parameter int MSG_W = VNU_MSG_W,
    parameter int WC    = VNU_WC,
    localparam int SUM_W = vnu_sum_w(MSG_W, WC)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [MSG_W-1:0]    lambda_i,
    input  logic [WC*MSG_W-1:0] c2v_i,
    output logic                out_valid,
    output logic [WC*MSG_W-1:0] v2c_o,
    output logic [SUM_W-1:0]    post_o
);
    localparam int NTERM = WC + 1;

    // Term 0 is the channel value, terms 1..WC are the check messages
    logic [NTERM-1:0][SUM_W-1:0] term_tc;
    logic [SUM_W-1:0]            total;
    logic [WC-1:0][SUM_W-1:0]    extr_tc;
    logic [WC*MSG_W-1:0]         extr_sm;

    vnu_sm2tc #(.IN_W(MSG_W), .OUT_W(SUM_W)) u_cv_lam (
        .sm_i (lambda_i),
        .tc_o (term_tc[0])
    );

    for (genvar s = 0; s < WC; s++) begin : g_in
        vnu_sm2tc #(.IN_W(MSG_W), .OUT_W(SUM_W)) u_cv (
            .sm_i (c2v_i[s*MSG_W +: MSG_W]),
            .tc_o (term_tc[s+1])
        );
    end

    vnu_accum #(.W(SUM_W), .N(NTERM)) u_acc (
        .term_i (term_tc),
        .sum_o  (total)
    );

    for (genvar s = 0; s < WC; s++) begin : g_out
        assign extr_tc[s] = total - term_tc[s+1];
        vnu_sat_tc2sm #(.IN_W(SUM_W), .OUT_W(MSG_W)) u_sat (
            .tc_i (extr_tc[s]),
            .sm_o (extr_sm[s*MSG_W +: MSG_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            v2c_o     <= '0;
            post_o    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                v2c_o  <= extr_sm;
                post_o <= total;
            end
        end
    end

endmodule

// File: rtl/vnu_core_chk.sv
module vnu_core_chk
    import vnu_pkg::*;
#(
    parameter int MSG_W = VNU_MSG_W,
    parameter int WC    = VNU_WC,
    localparam int SUM_W = vnu_sum_w(MSG_W, WC)
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [MSG_W-1:0]    lambda_i,
    input logic [WC*MSG_W-1:0] c2v_i,
    input logic                out_valid,
    input logic [WC*MSG_W-1:0] v2c_o,
    input logic [SUM_W-1:0]    post_o
);
    // Reference sum built from signed integers, not from the datapath
    int ref_sum;
    always_comb begin
        ref_sum = lambda_i[MSG_W-1] ? -int'(lambda_i[MSG_W-2:0]) : int'(lambda_i[MSG_W-2:0]);
        for (int s = 0; s < WC; s++) begin
            if (c2v_i[s*MSG_W + MSG_W - 1])
                ref_sum = ref_sum - int'(c2v_i[s*MSG_W +: MSG_W-1]);
            else
                ref_sum = ref_sum + int'(c2v_i[s*MSG_W +: MSG_W-1]);
        end
    end

    a_r6_valid_delay: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r6_idle_delay: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(v2c_o) && $stable(post_o)));
    a_r1_posterior: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (int'($signed(post_o)) == $past(ref_sum)));

    for (genvar s = 0; s < WC; s++) begin : g_slot
        a_r4_no_neg_zero: assert property (@(posedge clk) disable iff (rst)
            (v2c_o[s*MSG_W +: MSG_W-1] == '0) |-> !v2c_o[s*MSG_W + MSG_W - 1]);
        a_r5_first_pass: assert property (@(posedge clk) disable iff (rst)
            (in_valid && c2v_i == '0) |=>
            (v2c_o[s*MSG_W +: MSG_W] ==
             (($past(lambda_i[MSG_W-2:0]) == '0) ? '0 : $past(lambda_i))));
    end

endmodule

bind vnu_core vnu_core_chk #(.MSG_W(MSG_W), .WC(WC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .lambda_i  (lambda_i),
    .c2v_i     (c2v_i),
    .out_valid (out_valid),
    .v2c_o     (v2c_o),
    .post_o    (post_o)
);

// File: tb/sim_vnu_core.sv
`timescale 1ns/1ps
module sim_vnu_core;

    localparam int MW = 5;
    localparam int NW = 6;
    localparam int SW = 8;
    localparam int NV = 8;

    // Each row: channel value, then the six incoming messages (signed ints)
    localparam int TBL [NV][NW+1] = '{
        '{  3,   0,  0,   0,  0,   0,  0},
        '{ -5,   0,  0,   0,  0,   0,  0},
        '{ 15,  15, 15,  15, 15,  15, 15},
        '{-15, -15,-15, -15,-15, -15,-15},
        '{  2,   1, -1,   3, -4,   0,  2},
        '{ -9,   4,  4,  -2,  7,  -1,  3},
        '{  0,  -7,  7,  -7,  7,  -7,  7},
        '{ 10,   6,  0,   0,  0,   0,  0}
    };

    logic             clk = 1'b0;
    logic             rst;
    logic             in_valid;
    logic [MW-1:0]    lambda_i;
    logic [NW*MW-1:0] c2v_i;
    logic             out_valid;
    logic [NW*MW-1:0] v2c_o;
    logic [SW-1:0]    post_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    vnu_core u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .lambda_i  (lambda_i),
        .c2v_i     (c2v_i),
        .out_valid (out_valid),
        .v2c_o     (v2c_o),
        .post_o    (post_o)
    );

    function automatic logic [MW-1:0] enc(input int v);
        int m = (v < 0) ? -v : v;
        if (m > 15) m = 15;
        return {v < 0, 4'(m)};
    endfunction

    function automatic logic [MW-1:0] sat_enc(input int v);
        if (v > 15)  v = 15;
        if (v < -15) v = -15;
        return enc(v);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Compare all outputs against signed-integer expectations
    task automatic check_all(input string req, input int lam, input int m [NW]);
        int tot = lam;
        for (int s = 0; s < NW; s++) tot += m[s];
        check(out_valid == 1'b1, {req, " R6 out_valid"}, int'(out_valid), 1);
        check(int'($signed(post_o)) == tot, {req, " R1 post"}, int'($signed(post_o)), tot);
        for (int s = 0; s < NW; s++) begin
            logic [MW-1:0] e = sat_enc(tot - m[s]);
            check(v2c_o[s*MW +: MW] == e, {req, " R2 slot"},
                  int'(v2c_o[s*MW +: MW]), int'(e));
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int m [NW];
        logic [NW*MW-1:0] held_v2c;
        logic [SW-1:0]    held_post;

        rst = 1'b1; in_valid = 1'b0; lambda_i = '0; c2v_i = '0;
        repeat (3) @(negedge clk);
        // R8: reset state
        check(out_valid == 1'b0, "R8 out_valid", int'(out_valid), 0);
        check(v2c_o == '0, "R8 v2c", int'(v2c_o[MW-1:0]), 0);
        check(post_o == '0, "R8 post", int'(post_o), 0);
        rst = 1'b0;

        // Table walk: R1, R2, R3 (rows 2, 3, 7), R5 (rows 0, 1)
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            in_valid = 1'b1;
            lambda_i = enc(TBL[v][0]);
            for (int s = 0; s < NW; s++) begin
                m[s] = TBL[v][s+1];
                c2v_i[s*MW +: MW] = enc(m[s]);
            end
            @(negedge clk);
            in_valid = 1'b0;
            check_all((v == 2 || v == 3 || v == 7) ? "R3 table" :
                      (v < 2) ? "R5 table" : "R2 table", TBL[v][0], m);
        end

        // R4: all-negative-zero inputs produce positive zero everywhere
        @(negedge clk);
        in_valid = 1'b1;
        lambda_i = 5'b10000;
        c2v_i    = {NW{5'b10000}};
        @(negedge clk);
        in_valid = 1'b0;
        check(int'($signed(post_o)) == 0, "R4 negzero post", int'($signed(post_o)), 0);
        check(v2c_o == '0, "R4 negzero v2c", int'(v2c_o[MW-1:0]), 0);

        // R4: one negative-zero message among ordinary ones
        @(negedge clk);
        in_valid = 1'b1;
        lambda_i = enc(4);
        for (int s = 0; s < NW; s++) begin
            m[s] = (s == 0) ? 0 : 1;
            c2v_i[s*MW +: MW] = enc(m[s]);
        end
        c2v_i[MW-1:0] = 5'b10000;
        @(negedge clk);
        in_valid = 1'b0;
        check_all("R4 mixed", 4, m);

        // R7: inputs change while in_valid is low; outputs must not move
        held_v2c  = v2c_o;
        held_post = post_o;
        lambda_i  = enc(-13);
        c2v_i     = {NW{enc(9)}};
        @(negedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R6 idle out_valid", int'(out_valid), 0);
        check(v2c_o == held_v2c, "R7 hold v2c", int'(v2c_o[MW-1:0]), int'(held_v2c[MW-1:0]));
        check(post_o == held_post, "R7 hold post", int'(post_o), int'(held_post));

        // R8: reset after activity clears everything
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(out_valid == 1'b0 && post_o == '0 && v2c_o == '0, "R8 late reset",
              int'(post_o), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule